// File: doc/BRIEF.md
# Maskable Interrupt Gate with Pending Latches

This block sits between the interrupt sources of a small 8-bit CPU core and the core's interrupt entry logic. It keeps one pending latch for each maskable source numbered 15 down to 4, one enable bit for each of those sources, and a master enable flag. Hardware sources set their latch with a one-cycle pulse. Software reads and clears the latches and programs the enables over a byte-wide special-function-register bus. When a latch is pending, its source is enabled and the master flag is set, the block raises an accept request toward the CPU, together with the number of the winning source.

Four non-maskable request lines bypass all gating and take priority over maskable sources. When the CPU acknowledges a request, the block pushes the current master flag onto a small save stack and clears the flag. It also clears the latch of the maskable source that won. A return strobe pops the stack back into the master flag, so nested entries and returns restore the flag in the correct order. Two separate strobes set and clear the master flag directly.

Top module: `intr_gate_unit`

## Requirements
- R1: After reset the master flag, every enable bit, every pending latch and the save stack are 0, and all four register bytes read 0.
- R2: Register layout. Address 0x3A holds the master flag in bit 0 and the enables of sources 7..4 in bits 7..4; its bits 3..1 read 0. Address 0x3B holds the enables of sources 15..8. Address 0x3C shows the latches of sources 7..4 in bits 7..4, with bits 3..0 reading 0. Address 0x3D shows the latches of sources 15..8. Any other address reads 0, and a write to it changes nothing.
- R3: In a write to 0x3C or 0x3D, a 0 data bit clears the matching latch and a 1 bit leaves it unchanged; software can never set a latch.
- R4: A pulse on src_req bit k (source k+4) sets that latch at the next clock edge. The set wins over a software clear or an acknowledge clear of the same latch in the same cycle.
- R5: A maskable source can raise irq_req only while its latch, its enable bit and the master flag are all 1.
- R6: Among the maskable sources that are pending and allowed, the highest-numbered one wins; irq_id gives its source number (4..15) and irq_nmi is 0.
- R7: While any nmi_req bit is 1, irq_req and irq_nmi are 1 and irq_id is the highest set nmi_req index (0..3), whatever the registers and latches hold.
- R8: An irq_ack in a cycle with irq_req high pushes the master flag onto the save stack, clears the flag, and clears the latch of the selected maskable source. An irq_ack while irq_req is low has no effect.
- R9: A reti_strobe pops the top of the save stack into the master flag. The stack holds 4 entries. A push onto a full stack drops the oldest entry, and a pop of an empty stack yields 0.
- R10: ei_strobe sets and di_strobe clears the master flag at the next edge. When several writers of the flag act in the same cycle, the priority is: accepted acknowledge, then return, then di_strobe, then ei_strobe, then an SFR write to bit 0 of 0x3A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfr_addr | input | 8 | Register bus address |
| sfr_we | input | 1 | Register bus write strobe |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_rdata | output | 8 | Register bus read data (combinational from address) |
| ei_strobe | input | 1 | Set the master flag |
| di_strobe | input | 1 | Clear the master flag |
| src_req | input | 12 | Set pulses; bit k belongs to source k+4 |
| nmi_req | input | 4 | Non-maskable request lines |
| irq_ack | input | 1 | CPU accepts the current request |
| reti_strobe | input | 1 | Return from interrupt: restore the master flag |
| irq_req | output | 1 | Accept request toward the CPU |
| irq_nmi | output | 1 | Current request is non-maskable |
| irq_id | output | 4 | Number of the selected source |

## Verification
Two collisions are provoked on purpose. In the first, a request pulse lands in the same cycle as a software clear of the same latch, or as an acknowledge of that source; the latch read back afterwards must still be 1. In the second, an acknowledge and a return strobe, or the set and clear strobes, arrive together; the master flag read from 0x3A must follow the fixed priority order. The save stack is driven past its depth and drained past empty, and the sequence of restored flags is compared with a model of a four-entry stack.

// File: rtl/intr_gate_pkg.sv
package intr_gate_pkg;

    localparam int NSRC      = 16;
    localparam int FIRST_SRC = 4;
    localparam int NMASK     = NSRC - FIRST_SRC;
    localparam int NNMI      = 4;
    localparam int ID_W      = $clog2(NSRC);

    localparam logic [7:0] ADDR_EN_LO  = 8'h3A;
    localparam logic [7:0] ADDR_EN_HI  = 8'h3B;
    localparam logic [7:0] ADDR_LAT_LO = 8'h3C;
    localparam logic [7:0] ADDR_LAT_HI = 8'h3D;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_EN_LO,
        SEL_EN_HI,
        SEL_LAT_LO,
        SEL_LAT_HI
    } reg_sel_e;

    typedef struct packed {
        logic            req;
        logic            nmi;
        logic [ID_W-1:0] id;
    } pick_t;

    function automatic reg_sel_e decode_addr(input logic [7:0] a);
        case (a)
            ADDR_EN_LO:  return SEL_EN_LO;
            ADDR_EN_HI:  return SEL_EN_HI;
            ADDR_LAT_LO: return SEL_LAT_LO;
            ADDR_LAT_HI: return SEL_LAT_HI;
            default:     return SEL_NONE;
        endcase
    endfunction

    // index of the highest set bit, 0 when none is set
    function automatic logic [ID_W-1:0] top_bit(input logic [NSRC-1:0] v);
        logic [ID_W-1:0] r;
        r = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (v[i]) r = ID_W'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/igu_latch_bank.sv
module igu_latch_bank
    import intr_gate_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] set_vec,
    input  logic [NSRC-1:0] sw_clr,
    input  logic [NSRC-1:0] ack_clr,
    output logic [NSRC-1:0] lat_q
);

    for (genvar i = 0; i < NSRC; i++) begin : g_bit
        if (i < FIRST_SRC) begin : g_none
            assign lat_q[i] = 1'b0;
        end else begin : g_lat
            logic q;
            always_ff @(posedge clk) begin
                if (rst)             q <= 1'b0;
                else if (set_vec[i]) q <= 1'b1;
                else if (sw_clr[i] || ack_clr[i]) q <= 1'b0;
            end
            assign lat_q[i] = q;
        end
    end

endmodule

// File: rtl/igu_prio_pick.sv
module igu_prio_pick
    import intr_gate_pkg::*;
(
    input  logic [NSRC-1:0] pend,
    input  logic [NNMI-1:0] nmi,
    output pick_t           pick
);

    logic [NSRC-1:0] nmi_ext;

    always_comb begin
        nmi_ext = '0;
        nmi_ext[NNMI-1:0] = nmi;
        pick.nmi = |nmi;
        pick.req = (|nmi) || (|pend);
        pick.id  = (|nmi) ? top_bit(nmi_ext) : top_bit(pend);
    end

endmodule

// File: rtl/igu_imf_ctrl.sv
module igu_imf_ctrl #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic pop,
    input  logic clr,
    input  logic set,
    input  logic wr,
    input  logic wr_val,
    output logic imf_q,
    output logic stk_top
);

    logic [DEPTH-1:0] stk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            imf_q <= 1'b0;
            stk_q <= '0;
        end else if (take) begin
            stk_q <= {stk_q[DEPTH-2:0], imf_q};
            imf_q <= 1'b0;
        end else if (pop) begin
            imf_q <= stk_q[0];
            stk_q <= {1'b0, stk_q[DEPTH-1:1]};
        end else if (clr) begin
            imf_q <= 1'b0;
        end else if (set) begin
            imf_q <= 1'b1;
        end else if (wr) begin
            imf_q <= wr_val;
        end
    end

    assign stk_top = stk_q[0];

endmodule

// File: rtl/intr_gate_unit.sv
module intr_gate_unit
    import intr_gate_pkg::*;
#(
    parameter int STACK_DEPTH = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [7:0]                    sfr_addr,
    input  logic                          sfr_we,
    input  logic [7:0]                    sfr_wdata,
    output logic [7:0]                    sfr_rdata,
    input  logic                          ei_strobe,
    input  logic                          di_strobe,
    input  logic [NSRC-1:FIRST_SRC]       src_req,
    input  logic [NNMI-1:0]               nmi_req,
    input  logic                          irq_ack,
    input  logic                          reti_strobe,
    output logic                          irq_req,
    output logic                          irq_nmi,
    output logic [ID_W-1:0]               irq_id
);

    reg_sel_e        sel;
    logic [NSRC-1:0] en_q;
    logic [NSRC-1:0] lat_q;
    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] sw_clr;
    logic [NSRC-1:0] ack_clr;
    logic [NSRC-1:0] pend;
    logic            imf_q;
    logic            stk_top;
    logic            take;
    pick_t           pick;

    assign sel = decode_addr(sfr_addr);

    // enable register
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
        end else if (sfr_we) begin
            if (sel == SEL_EN_LO) en_q[7:FIRST_SRC] <= sfr_wdata[7:FIRST_SRC];
            if (sel == SEL_EN_HI) en_q[15:8]        <= sfr_wdata;
        end
    end

    always_comb begin
        set_vec = '0;
        set_vec[NSRC-1:FIRST_SRC] = src_req;
        sw_clr = '0;
        if (sfr_we && sel == SEL_LAT_LO) sw_clr[7:FIRST_SRC] = ~sfr_wdata[7:FIRST_SRC];
        if (sfr_we && sel == SEL_LAT_HI) sw_clr[15:8]        = ~sfr_wdata;
        ack_clr = '0;
        if (take && !pick.nmi) ack_clr[pick.id] = 1'b1;
        pend = lat_q & en_q & {NSRC{imf_q}};
    end

    igu_latch_bank u_lat (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .sw_clr  (sw_clr),
        .ack_clr (ack_clr),
        .lat_q   (lat_q)
    );

    igu_prio_pick u_pick (
        .pend (pend),
        .nmi  (nmi_req),
        .pick (pick)
    );

    assign take = irq_ack && pick.req;

    igu_imf_ctrl #(.DEPTH(STACK_DEPTH)) u_imf (
        .clk     (clk),
        .rst     (rst),
        .take    (take),
        .pop     (reti_strobe),
        .clr     (di_strobe),
        .set     (ei_strobe),
        .wr      (sfr_we && sel == SEL_EN_LO),
        .wr_val  (sfr_wdata[0]),
        .imf_q   (imf_q),
        .stk_top (stk_top)
    );

    always_comb begin
        case (sel)
            SEL_EN_LO:  sfr_rdata = {en_q[7:FIRST_SRC], 3'b000, imf_q};
            SEL_EN_HI:  sfr_rdata = en_q[15:8];
            SEL_LAT_LO: sfr_rdata = {lat_q[7:FIRST_SRC], 4'b0000};
            SEL_LAT_HI: sfr_rdata = lat_q[15:8];
            default:    sfr_rdata = 8'h00;
        endcase
    end

    assign irq_req = pick.req;
    assign irq_nmi = pick.nmi;
    assign irq_id  = pick.id;

endmodule

// File: rtl/intr_gate_chk.sv
module intr_gate_chk
    import intr_gate_pkg::*;
(
    input logic                    clk,
    input logic                    rst,
    input logic [NSRC-1:FIRST_SRC] src_req,
    input logic [NNMI-1:0]         nmi_req,
    input logic                    irq_ack,
    input logic                    reti_strobe,
    input logic                    di_strobe,
    input logic                    irq_req,
    input logic                    irq_nmi,
    input logic [ID_W-1:0]         irq_id,
    input logic [NSRC-1:0]         lat_q,
    input logic [NSRC-1:0]         en_q,
    input logic                    imf_q,
    input logic                    stk_top
);

    assert_set_sticks_R4: assert property (@(posedge clk) disable iff (rst)
        (src_req != '0) |=> ((lat_q[NSRC-1:FIRST_SRC] & $past(src_req)) == $past(src_req)));

    assert_mask_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (irq_req && !irq_nmi) |-> (imf_q && lat_q[irq_id] && en_q[irq_id]));

    assert_nmi_bypass_R7: assert property (@(posedge clk) disable iff (rst)
        (nmi_req != '0) |-> (irq_req && irq_nmi));

    assert_ack_clears_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req) |=> !imf_q);

    assert_reti_restores_R9: assert property (@(posedge clk) disable iff (rst)
        (reti_strobe && !(irq_ack && irq_req)) |=> (imf_q == $past(stk_top)));

    assert_di_clears_R10: assert property (@(posedge clk) disable iff (rst)
        (di_strobe && !reti_strobe) |=> !imf_q);

endmodule

bind intr_gate_unit intr_gate_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .src_req     (src_req),
    .nmi_req     (nmi_req),
    .irq_ack     (irq_ack),
    .reti_strobe (reti_strobe),
    .di_strobe   (di_strobe),
    .irq_req     (irq_req),
    .irq_nmi     (irq_nmi),
    .irq_id      (irq_id),
    .lat_q       (lat_q),
    .en_q        (en_q),
    .imf_q       (imf_q),
    .stk_top     (stk_top)
);

// File: tb/intr_gate_unit_tb.sv
module intr_gate_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  sfr_addr = 8'h00;
    logic        sfr_we = 1'b0;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic        ei_strobe = 1'b0;
    logic        di_strobe = 1'b0;
    logic [15:4] src_req = '0;
    logic [3:0]  nmi_req = '0;
    logic        irq_ack = 1'b0;
    logic        reti_strobe = 1'b0;
    logic        irq_req;
    logic        irq_nmi;
    logic [3:0]  irq_id;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    intr_gate_unit dut_i (
        .clk         (clk),
        .rst         (rst),
        .sfr_addr    (sfr_addr),
        .sfr_we      (sfr_we),
        .sfr_wdata   (sfr_wdata),
        .sfr_rdata   (sfr_rdata),
        .ei_strobe   (ei_strobe),
        .di_strobe   (di_strobe),
        .src_req     (src_req),
        .nmi_req     (nmi_req),
        .irq_ack     (irq_ack),
        .reti_strobe (reti_strobe),
        .irq_req     (irq_req),
        .irq_nmi     (irq_nmi),
        .irq_id      (irq_id)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        sfr_addr = a; sfr_wdata = d; sfr_we = 1'b1;
        cyc();
        sfr_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a;
        #1;
        d = sfr_rdata;
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
        logic [7:0] d;
        rd(a, d);
        chk(d == exp, tag, d, exp);
    endtask

    task automatic chk_imf(input bit exp, input string tag);
        logic [7:0] d;
        rd(8'h3A, d);
        chk(d[0] == exp, tag, d[0], exp);
    endtask

    task automatic pulse_ei();  ei_strobe = 1'b1; cyc(); ei_strobe = 1'b0; endtask
    task automatic pulse_di();  di_strobe = 1'b1; cyc(); di_strobe = 1'b0; endtask
    task automatic pulse_ack(); irq_ack = 1'b1;   cyc(); irq_ack = 1'b0;   endtask
    task automatic pulse_ret(); reti_strobe = 1'b1; cyc(); reti_strobe = 1'b0; endtask

    function automatic int top_src(input logic [11:0] m);
        int r = -1;
        for (int i = 0; i < 12; i++) if (m[i]) r = i + 4;
        return r;
    endfunction

    initial begin
        #(8 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) cyc();
        rst = 1'b0;

        // R1 reset state
        chk_rd(8'h3A, 8'h00, "R1 en_lo");
        chk_rd(8'h3B, 8'h00, "R1 en_hi");
        chk_rd(8'h3C, 8'h00, "R1 lat_lo");
        chk_rd(8'h3D, 8'h00, "R1 lat_hi");
        chk(irq_req == 1'b0, "R1 irq_req", irq_req, 0);

        // R2 layout and unused bits
        wr(8'h3A, 8'hFF);
        chk_rd(8'h3A, 8'hF1, "R2 en_lo bits3..1 zero");
        wr(8'h3B, 8'hA5);
        chk_rd(8'h3B, 8'hA5, "R2 en_hi");
        wr(8'h3E, 8'hFF);
        chk_rd(8'h3E, 8'h00, "R2 unmapped read");
        chk_rd(8'h3B, 8'hA5, "R2 unmapped write no effect");
        chk_rd(8'h3A, 8'hF1, "R2 unmapped write no effect lo");
        wr(8'h3A, 8'h00);
        wr(8'h3B, 8'h00);

        // R4 set pulse; R2 low latch nibble reads zero
        src_req = 12'hFFF; cyc(); src_req = '0;
        chk_rd(8'h3C, 8'hF0, "R2 lat_lo low nibble zero");
        chk_rd(8'h3D, 8'hFF, "R4 lat_hi set");
        // R3 example clear pattern: clears 12 and 10..6
        wr(8'h3C, 8'h3F);
        wr(8'h3D, 8'hE8);
        chk_rd(8'h3C, 8'h30, "R3 lat_lo cleared by zeros");
        chk_rd(8'h3D, 8'hE8, "R3 lat_hi ones keep");
        wr(8'h3D, 8'hFF);
        chk_rd(8'h3D, 8'hE8, "R3 software cannot set");
        // R4 set wins over software clear
        sfr_addr = 8'h3D; sfr_wdata = 8'h00; sfr_we = 1'b1; src_req[13] = 1'b1;
        cyc();
        sfr_we = 1'b0; src_req = '0;
        chk_rd(8'h3D, 8'h20, "R4 set beats clear");
        wr(8'h3C, 8'h00); wr(8'h3D, 8'h00);

        // R6/R5 near-exhaustive sweep over pending and enable patterns
        for (int p = 0; p < 4096; p++) begin
            logic [11:0] pv;
            logic [11:0] ev;
            int exp_id;
            pv = 12'(p);
            ev = 12'((p * 7 + 3) & 12'hFFF);
            src_req = pv; cyc(); src_req = '0;
            wr(8'h3A, {ev[3:0], 4'b0001});
            wr(8'h3B, ev[11:4]);
            exp_id = top_src(pv & ev);
            #1;
            if (exp_id < 0) begin
                chk(irq_req == 1'b0, "R6 no request", irq_req, 0);
            end else begin
                chk(irq_req && !irq_nmi && irq_id == 4'(exp_id), "R6 priority id",
                    {irq_req, irq_nmi, irq_id}, {2'b10, 4'(exp_id)});
            end
            pulse_di();
            #1;
            chk(irq_req == 1'b0, "R5 master flag gates", irq_req, 0);
            wr(8'h3C, 8'h00); wr(8'h3D, 8'h00);
        end

        // R8 accept clears latch and master flag, R9 return restores
        wr(8'h3B, 8'h02);
        wr(8'h3A, 8'h01);
        src_req[9] = 1'b1; cyc(); src_req = '0;
        #1;
        chk(irq_req && irq_id == 4'd9, "R8 request for 9", irq_id, 9);
        pulse_ack();
        chk_rd(8'h3D, 8'h00, "R8 ack clears latch 9");
        chk_imf(1'b0, "R8 ack clears master");
        chk(irq_req == 1'b0, "R8 no request after ack", irq_req, 0);
        pulse_ret();
        chk_imf(1'b1, "R9 reti restores 1");
        // R4 set beats ack clear
        src_req[9] = 1'b1; cyc();
        irq_ack = 1'b1; cyc(); irq_ack = 1'b0; src_req = '0;
        chk_rd(8'h3D, 8'h02, "R4 set beats ack clear");
        pulse_ret();
        wr(8'h3D, 8'h00);
        // R8 ack without request ignored
        chk_imf(1'b1, "R8 precondition");
        pulse_ack();
        chk_imf(1'b1, "R8 idle ack ignored");

        // R7 nmi bypass
        pulse_di();
        wr(8'h3B, 8'h00);
        nmi_req = 4'b0101;
        #1;
        chk(irq_req && irq_nmi && irq_id == 4'd2, "R7 nmi with all gating off",
            {irq_req, irq_nmi, irq_id}, 6'b110010);
        wr(8'h3B, 8'hFF); wr(8'h3A, 8'hF1);
        src_req[15] = 1'b1; cyc(); src_req = '0;
        #1;
        chk(irq_nmi && irq_id == 4'd2, "R7 nmi beats maskable", irq_id, 2);
        pulse_ack();
        chk_rd(8'h3D, 8'h80, "R7 nmi ack keeps latch 15");
        chk_imf(1'b0, "R8 nmi ack clears master");
        pulse_ret();
        wr(8'h3D, 8'h00);

        // R9 nesting order with nmi holding the request
        nmi_req = 4'b0001;
        for (int k = 0; k < 5; k++) pulse_ret();
        pulse_ei();
        pulse_ack();              // push 1
        pulse_ack();              // push 0
        pulse_ei();
        pulse_ack();              // push 1
        pulse_ret(); chk_imf(1'b1, "R9 pop 1st");
        pulse_ret(); chk_imf(1'b0, "R9 pop 2nd");
        pulse_ret(); chk_imf(1'b1, "R9 pop 3rd");
        pulse_ret(); chk_imf(1'b0, "R9 pop empty");
        // R9 overflow drops oldest
        pulse_ei();
        pulse_ack();              // push 1 (becomes oldest, dropped)
        for (int k = 0; k < 4; k++) pulse_ack();   // push 0 four times
        for (int k = 0; k < 4; k++) begin
            pulse_ret(); chk_imf(1'b0, "R9 drained entry");
        end
        pulse_ret(); chk_imf(1'b0, "R9 depth bound, oldest dropped");

        // R10 strobes and priority
        chk_imf(1'b0, "R10 before ei");
        ei_strobe = 1'b1;
        #1;
        chk_imf(1'b0, "R10 ei not yet applied");
        cyc(); ei_strobe = 1'b0;
        chk_imf(1'b1, "R10 ei applied next edge");
        ei_strobe = 1'b1; di_strobe = 1'b1; cyc(); ei_strobe = 1'b0; di_strobe = 1'b0;
        chk_imf(1'b0, "R10 di beats ei");
        sfr_addr = 8'h3A; sfr_wdata = 8'h01; sfr_we = 1'b1; di_strobe = 1'b1;
        cyc(); sfr_we = 1'b0; di_strobe = 1'b0;
        chk_imf(1'b0, "R10 di beats sfr write");
        pulse_ei();
        irq_ack = 1'b1; reti_strobe = 1'b1; cyc(); irq_ack = 1'b0; reti_strobe = 1'b0;
        chk_imf(1'b0, "R10 ack beats reti");
        pulse_ret();
        chk_imf(1'b1, "R10 pushed value restored");
        nmi_req = '0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule